// File: doc/BRIEF.md
# Post-Trigger Signal Stability Monitor

This block is a synthesizable runtime checker for two single-bit inputs that share one clock. A rising edge on the trigger input `trig_i` starts an observation period. At that edge the block captures a 16-bit grace length from `win_len_i`. For that many cycles the watched input `sig_i` may toggle freely. When the grace window has run out, `sig_i` has to keep its value on every clock until the next trigger rising edge. Any change in that interval is a violation.

A violation produces a one-cycle pulse on `viol_o` and sets the sticky flag `viol_sticky_o`. Only reset clears the flag. `win_active_o` is high while the grace counter is nonzero, so the window boundaries can be seen from outside. All pins are plain control and status pins: the block carries no data stream, so there is no valid/ready handshake and no back-pressure. Reset is synchronous and active high.

Top module: `stab_monitor`

## Requirements
- R1: A trigger rising edge is a cycle in which `trig_i` is 1 while its sample from the previous clock was 0. The block takes that sample on every clock, including reset cycles. On that edge the window counter loads `win_len_i`.
- R2: A change on `sig_i` is flagged only when it arrives while the counter reads zero. `sig_i` counts as changed when it differs from its sample on the previous clock.
- R3: With the block armed and the counter at zero, a change of `sig_i` in cycle t drives `viol_o` high in cycle t+1. `viol_o` stays high for that one cycle only, unless the next cycle also has a change.
- R4: After loading, the counter drops by one each clock and holds at zero without wrapping. `win_active_o` is 1 exactly while the counter is nonzero. A trigger edge with length N gives N cycles of `win_active_o`. Changes in the N cycles after the edge are allowed, and a change N+1 cycles after the edge is flagged.
- R5: A length of 0 opens no window. A change in the very next cycle after the trigger edge is flagged.
- R6: A trigger rising edge in the middle of an open window reloads the counter with the new length. A change of `sig_i` in the same cycle as a trigger rising edge is never flagged.
- R7: From reset until the first trigger rising edge, no change of `sig_i` is flagged.
- R8: `viol_sticky_o` becomes 1 in the same cycle as the first `viol_o` pulse and then stays 1 until reset.
- R9: While reset is held and in the first cycle after it, `viol_o`, `viol_sticky_o` and `win_active_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Trigger; its rising edge opens a new period |
| sig_i | input | 1 | Watched signal |
| win_len_i | input | 16 | Grace length in cycles, captured on the trigger edge |
| viol_o | output | 1 | One-cycle pulse for each stability violation |
| viol_sticky_o | output | 1 | Set by any violation, cleared only by reset |
| win_active_o | output | 1 | High while the grace counter is nonzero |

## Verification
The assertions check four things on every clock:
- the counter's load, decrement and hold-at-zero behaviour;
- that no pulse appears while unarmed, inside the window, or right after a trigger edge;
- that the sticky flag never drops;
- that every pulse is mirrored in the sticky flag.

Some behaviours only the bench scenarios can show. The first is the exact cycle at which a flagged change begins, which the bench finds by sweeping every change offset against several lengths. The bench scenarios also cover retriggering in the middle of a window, the zero-length case, and long runs of stable periods that must stay silent.

// File: rtl/stab_pkg.sv
package stab_pkg;
  localparam int unsigned STAB_CNT_W = 16;

  typedef enum logic {
    ARM_IDLE  = 1'b0,
    ARM_WATCH = 1'b1
  } arm_state_t;
endpackage

// File: rtl/stab_input_sampler.sv
module stab_input_sampler #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // One flop per lane; reset loads the live value so leaving reset
  // never shows up as an edge or a change.
  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk) begin
      q[i] <= d[i];
    end
  end
endmodule

// File: rtl/stab_window_ctr.sv
module stab_window_ctr #(
  parameter int unsigned CNT_W = stab_pkg::STAB_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             active_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (load)              cnt_d = len;
    else if (cnt_q != ZERO) cnt_d = cnt_q - ONE;
    else                   cnt_d = ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= ZERO;
    else     cnt_q <= cnt_d;
  end

  assign active_o  = (cnt_q != ZERO);
  assign expired_o = (cnt_q == ZERO);

  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(len));
  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != ZERO) |=> cnt_q == $past(cnt_q) - ONE);
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == ZERO) |=> cnt_q == ZERO);
endmodule

// File: rtl/stab_violation_track.sv
module stab_violation_track (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic chg,
  input  logic expired,
  output logic armed_o,
  output logic viol_o,
  output logic sticky_o
);
  import stab_pkg::*;

  arm_state_t st_q;
  logic       hit;

  assign hit = (st_q == ARM_WATCH) && expired && chg && !rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ARM_IDLE;
      viol_o   <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      if (rise) st_q <= ARM_WATCH;
      viol_o   <= hit;
      sticky_o <= sticky_o | hit;
    end
  end

  assign armed_o = (st_q == ARM_WATCH);

  p_sticky_holds_r8: assert property (@(posedge clk) disable iff (rst)
    sticky_o |=> sticky_o);
  p_pulse_sets_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> sticky_o);
  p_stays_armed_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ARM_WATCH) |=> (st_q == ARM_WATCH));
endmodule

// File: rtl/stab_monitor.sv
module stab_monitor #(
  parameter int unsigned CNT_W = stab_pkg::STAB_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic             sig_i,
  input  logic [CNT_W-1:0] win_len_i,
  output logic             viol_o,
  output logic             viol_sticky_o,
  output logic             win_active_o
);
  localparam int unsigned LANES = 2;
  localparam int unsigned L_TRIG = 0;
  localparam int unsigned L_SIG  = 1;

  logic [LANES-1:0] live;
  logic [LANES-1:0] prev;
  logic             rise;
  logic             chg;
  logic             expired;
  logic             armed;

  assign live[L_TRIG] = trig_i;
  assign live[L_SIG]  = sig_i;

  stab_input_sampler #(.W(LANES)) u_smp (
    .clk (clk),
    .rst (rst),
    .d   (live),
    .q   (prev)
  );

  assign rise = live[L_TRIG] & ~prev[L_TRIG];
  assign chg  = live[L_SIG] ^ prev[L_SIG];

  stab_window_ctr #(.CNT_W(CNT_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .load      (rise),
    .len       (win_len_i),
    .active_o  (win_active_o),
    .expired_o (expired)
  );

  stab_violation_track u_trk (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise),
    .chg      (chg),
    .expired  (expired),
    .armed_o  (armed),
    .viol_o   (viol_o),
    .sticky_o (viol_sticky_o)
  );

  p_unarmed_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !viol_o);
  p_window_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    win_active_o |=> !viol_o);
  p_rise_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    rise |=> !viol_o);
endmodule

// File: tb/sim_stab_monitor.sv
`timescale 1ns/1ps
module sim_stab_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic        sig = 1'b0;
  logic [15:0] len = '0;
  logic        viol, sticky, active;

  int errors = 0;
  int checks = 0;
  int act_seen = 0;
  int viol_seen = 0;

  always #10 clk = ~clk;

  stab_monitor u0 (
    .clk(clk), .rst(rst), .trig_i(trig), .sig_i(sig), .win_len_i(len),
    .viol_o(viol), .viol_sticky_o(sticky), .win_active_o(active)
  );

  // Reference model built from the requirements.
  logic        m_tp, m_sp, m_arm, m_viol, m_sticky;
  logic [15:0] m_cnt;
  always @(posedge clk) begin
    logic r, c, h;
    r = trig & ~m_tp;
    c = sig ^ m_sp;
    h = m_arm && (m_cnt == 0) && c && !r;
    m_tp <= trig;
    m_sp <= sig;
    if (rst) begin
      m_arm <= 1'b0; m_viol <= 1'b0; m_sticky <= 1'b0; m_cnt <= '0;
    end else begin
      if (r) m_arm <= 1'b1;
      m_cnt    <= r ? len : (m_cnt != 0 ? m_cnt - 16'd1 : 16'd0);
      m_viol   <= h;
      m_sticky <= m_sticky | h;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Sample outputs after the previous edge, then drive the next cycle.
  task automatic cyc(input logic a, input logic b, input logic [15:0] n);
    @(negedge clk);
    if (!rst) begin
      check("R3", viol, m_viol);
      check("R4", active, (m_cnt != 0));
      check("R8", sticky, m_sticky);
    end
    act_seen  += int'(active);
    viol_seen += int'(viol);
    trig = a; sig = b; len = n;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(trig, sig, len);
    cyc(trig, sig, len);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic b;
    do_reset();
    @(negedge clk);
    check("R9", viol, 1'b0);
    check("R9", sticky, 1'b0);
    check("R9", active, 1'b0);

    // R7: toggling before any trigger edge is ignored
    viol_seen = 0;
    for (int i = 0; i < 6; i++) cyc(1'b0, i[0], 16'd0);
    cyc(1'b0, 1'b0, 16'd0);
    check_int("R7", viol_seen, 0);
    check("R7", sticky, 1'b0);

    // R5: zero length, change on the cycle after the edge is flagged
    cyc(1'b0, 1'b0, 16'd0);
    cyc(1'b1, 1'b0, 16'd0);
    viol_seen = 0;
    cyc(1'b1, 1'b1, 16'd0);
    cyc(1'b1, 1'b1, 16'd0);
    cyc(1'b1, 1'b1, 16'd0);
    check_int("R5", viol_seen, 1);
    check("R8", sticky, 1'b1);

    // Sweep: length N, single change k cycles after the edge
    b = 1'b1;
    for (int n = 0; n <= 5; n++) begin
      for (int k = 1; k <= n + 2; k++) begin
        cyc(1'b0, b, 16'd0);
        cyc(1'b1, b, 16'(n));
        act_seen = 0; viol_seen = 0;
        for (int i = 1; i <= n + 4; i++) cyc(1'b1, (i >= k) ? ~b : b, 16'd0);
        cyc(1'b1, ~b, 16'd0);
        b = ~b;
        check_int("R4", act_seen, n);
        if (k > n) check_int("R3", viol_seen, 1);
        else       check_int("R2", viol_seen, 0);
      end
    end

    // R6: retrigger mid-window with a shorter length
    cyc(1'b0, b, 16'd0);
    cyc(1'b1, b, 16'd6);
    cyc(1'b1, b, 16'd0);
    cyc(1'b0, b, 16'd0);
    b = ~b;
    act_seen = 0; viol_seen = 0;
    cyc(1'b1, b, 16'd2);            // change in the rise cycle itself
    cyc(1'b1, ~b, 16'd0);            // inside new window
    cyc(1'b1, b, 16'd0);             // inside new window
    cyc(1'b1, ~b, 16'd0);            // window expired: flagged
    cyc(1'b1, ~b, 16'd0);
    b = ~b;
    check_int("R6", viol_seen, 1);
    check_int("R6", act_seen, 3);

    // R2: several stable periods raise nothing
    viol_seen = 0;
    for (int p = 0; p < 4; p++) begin
      cyc(1'b0, b, 16'd0);
      cyc(1'b1, b, 16'(p));
      for (int i = 0; i < 5; i++) cyc(1'b1, b, 16'd0);
    end
    cyc(1'b1, b, 16'd0);
    check_int("R2", viol_seen, 0);
    check("R8", sticky, 1'b1);

    // R9: reset clears the sticky flag
    do_reset();
    @(negedge clk);
    check("R9", sticky, 1'b0);
    check("R9", active, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule